// File: doc/BRIEF.md
# Software Write-Protect Command Detector

This block sits in front of the page-load logic of a byte-wide nonvolatile memory and watches every write cycle (a one-cycle strobe with a 15-bit address and 8-bit data). It recognises two fixed address/data key sequences. A three-byte arming prefix followed by a data byte stores that byte and turns protection on. A six-byte disarm sequence turns protection off and stores nothing.

For each strobed write the block says, in the same cycle, whether the byte may be stored (`wr_permit`) or whether it is a key byte that must be discarded (`wr_cmd`). While protection is on, only a byte that directly follows the arming prefix is stored. The protected flag models a nonvolatile bit. The power-on reset clears it. The ordinary reset only abandons a partly matched sequence.

Top module: `swp_key_guard`

## Requirements
- R1: While `por_n` is low, `prot_on` is 0 and any partial key match is cleared. After release the block is unprotected.
- R2: With protection off, a strobed write that is not a key byte gives `wr_permit`=1 and `wr_cmd`=0.
- R3: The arming prefix is 5555h/AAh, then 2AAAh/55h, then 5555h/A0h. Each prefix byte gives `wr_cmd`=1 and `wr_permit`=0. The next write gives `wr_permit`=1, whatever its address and data, and `prot_on` reads 1 from the following cycle.
- R4: With protection on, a write that does not follow the arming prefix gives `wr_permit`=0 and `wr_cmd`=0, and `prot_on` stays 1.
- R5: With protection on, a write that follows the arming prefix gives `wr_permit`=1, and `prot_on` stays 1.
- R6: The disarm sequence is 5555h/AAh, 2AAAh/55h, 5555h/80h, 5555h/AAh, 2AAAh/55h, 5555h/20h. Every byte of it gives `wr_cmd`=1 and `wr_permit`=0. `prot_on` reads 0 from the cycle after the last byte, and later plain writes are permitted.
- R7: Key addresses are compared on address bits 13..0 only, so bit 14 is ignored. For example, 6AAAh matches 2AAAh and 1555h matches 5555h.
- R8: A write that breaks an expected sequence returns the matcher to idle and is judged under the current protection state. If that write is itself 5555h/AAh, it starts a new sequence and gives `wr_cmd`=1.
- R9: While `rst_n` is low, `wr_permit` and `wr_cmd` are 0, the matcher returns to idle and `prot_on` keeps its value.
- R10: When `wr_stb` is 0, `wr_permit` and `wr_cmd` are 0 and no state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears protection |
| rst_n | input | 1 | Ordinary reset, active low, synchronous; clears the matcher only |
| wr_stb | input | 1 | One-cycle write strobe |
| wr_addr | input | 15 | Write address |
| wr_data | input | 8 | Write data |
| wr_permit | output | 1 | The strobed byte may be stored |
| wr_cmd | output | 1 | The strobed byte is a key byte and must be discarded |
| prot_on | output | 1 | Protected mode is active |

## Verification
The assertions assume that address, data and strobe are stable around each rising edge and that a write lasts exactly one strobed cycle. They also assume `por_n` is asserted once at start-up before any strobe. The bench drives every input on the falling edge, raises the strobe for one cycle per write and samples the combinational verdicts just after the drive. It samples `prot_on` only after the edge that ends a write, so every change is seen one full register stage later.

// File: rtl/swp_key_guard.sv
module swp_key_guard #(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_MASK = 15'h3FFF,
  parameter logic [ADDR_W-1:0] ADDR_P = 15'h5555,
  parameter logic [ADDR_W-1:0] ADDR_Q = 15'h2AAA,
  parameter logic [DATA_W-1:0] DAT_OPEN = 8'hAA,
  parameter logic [DATA_W-1:0] DAT_TWO = 8'h55,
  parameter logic [DATA_W-1:0] DAT_ARM = 8'hA0,
  parameter logic [DATA_W-1:0] DAT_ERASE = 8'h80,
  parameter logic [DATA_W-1:0] DAT_OFF = 8'h20
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              wr_permit,
  output logic              wr_cmd,
  output logic              prot_on
);

  typedef enum logic [2:0] {
    M_IDLE, M_K1, M_K2, M_ARMED, M_K3, M_K4, M_K5
  } mstate_t;

  mstate_t st, nxt;
  logic    step, arm_use, disarm;

  wire at_p = ((wr_addr ^ ADDR_P) & KEY_MASK) == '0;
  wire at_q = ((wr_addr ^ ADDR_Q) & KEY_MASK) == '0;
  wire k_open  = at_p && (wr_data == DAT_OPEN);
  wire k_two   = at_q && (wr_data == DAT_TWO);
  wire k_arm   = at_p && (wr_data == DAT_ARM);
  wire k_erase = at_p && (wr_data == DAT_ERASE);
  wire k_off   = at_p && (wr_data == DAT_OFF);
  wire go      = wr_stb && rst_n;

  always_comb begin
    nxt     = M_IDLE;
    step    = 1'b0;
    arm_use = 1'b0;
    disarm  = 1'b0;
    case (st)
      M_ARMED: arm_use = 1'b1;
      M_K1: if (k_two) begin nxt = M_K2; step = 1'b1; end
            else if (k_open) begin nxt = M_K1; step = 1'b1; end
      M_K2: if (k_arm) begin nxt = M_ARMED; step = 1'b1; end
            else if (k_erase) begin nxt = M_K3; step = 1'b1; end
            else if (k_open) begin nxt = M_K1; step = 1'b1; end
      M_K3: if (k_open) begin nxt = M_K4; step = 1'b1; end
      M_K4: if (k_two) begin nxt = M_K5; step = 1'b1; end
            else if (k_open) begin nxt = M_K1; step = 1'b1; end
      M_K5: if (k_off) begin nxt = M_IDLE; step = 1'b1; disarm = 1'b1; end
            else if (k_open) begin nxt = M_K1; step = 1'b1; end
      default: if (k_open) begin nxt = M_K1; step = 1'b1; end
    endcase
  end

  assign wr_cmd    = go && step;
  assign wr_permit = go && !step && (arm_use || !prot_on);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      st      <= M_IDLE;
      prot_on <= 1'b0;
    end else if (!rst_n) begin
      st <= M_IDLE;
    end else if (wr_stb) begin
      st <= nxt;
      if (arm_use) prot_on <= 1'b1;
      else if (disarm) prot_on <= 1'b0;
    end
  end

endmodule

// File: rtl/swp_key_guard_chk.sv
module swp_key_guard_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              por_n,
  input logic              rst_n,
  input logic              wr_stb,
  input logic [DATA_W-1:0] wr_data,
  input logic              wr_permit,
  input logic              wr_cmd,
  input logic              prot_on
);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!por_n)
    !wr_stb |-> (!wr_permit && !wr_cmd));

  p_reset_inhibit_r9: assert property (@(posedge clk) disable iff (!por_n)
    !rst_n |-> (!wr_permit && !wr_cmd));

  p_flag_hold_r9: assert property (@(posedge clk) disable iff (!por_n)
    !(wr_stb && rst_n) |=> $stable(prot_on));

  p_verdict_excl_r6: assert property (@(posedge clk) disable iff (!por_n)
    !(wr_permit && wr_cmd));

  p_arm_by_write_r3: assert property (@(posedge clk) disable iff (!por_n)
    $rose(prot_on) |-> $past(wr_permit));

  p_disarm_by_key_r6: assert property (@(posedge clk) disable iff (!por_n)
    $fell(prot_on) |-> $past(wr_cmd && wr_data == 8'h20));

endmodule

bind swp_key_guard swp_key_guard_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_stb(wr_stb),
  .wr_data(wr_data), .wr_permit(wr_permit), .wr_cmd(wr_cmd),
  .prot_on(prot_on)
);

// File: tb/swp_key_guard_test.sv
module swp_key_guard_test;
  logic clk = 1'b0;
  logic por_n = 1'b0, rst_n = 1'b0, wr_stb = 1'b0;
  logic [14:0] wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic wr_permit, wr_cmd, prot_on;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  swp_key_guard uut (
    .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_permit(wr_permit),
    .wr_cmd(wr_cmd), .prot_on(prot_on)
  );

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [14:0] a, input logic [7:0] d,
                    input logic ep, input logic ec, input string req);
    @(negedge clk);
    wr_stb = 1'b1; wr_addr = a; wr_data = d;
    #1;
    chk({req, " permit"}, wr_permit, ep);
    chk({req, " cmd"}, wr_cmd, ec);
    @(posedge clk);
    #1 wr_stb = 1'b0;
  endtask

  task automatic chk_prot(logic exp, string req);
    @(negedge clk);
    chk({req, " prot_on"}, prot_on, exp);
  endtask

  task automatic t_reset();
    wr_addr = 15'h5555; wr_data = 8'hAA;
    #1;
    chk("R1 por prot", prot_on, 1'b0);
    @(negedge clk); por_n = 1'b1; rst_n = 1'b1;
    #1;
    chk("R10 idle permit", wr_permit, 1'b0);
    chk("R10 idle cmd", wr_cmd, 1'b0);
    chk_prot(1'b0, "R1 after release");
  endtask

  task automatic t_plain();
    wr(15'h0123, 8'h5A, 1, 0, "R2 plain a");
    wr(15'h7FFF, 8'hFF, 1, 0, "R2 plain b");
  endtask

  task automatic arm_prefix(string req);
    wr(15'h5555, 8'hAA, 0, 1, req);
    wr(15'h2AAA, 8'h55, 0, 1, req);
    wr(15'h5555, 8'hA0, 0, 1, req);
  endtask

  task automatic t_enable();
    arm_prefix("R3 prefix");
    chk_prot(1'b0, "R3 before data");
    wr(15'h5555, 8'hAA, 1, 0, "R3 data after prefix");
    chk_prot(1'b1, "R3 armed");
  endtask

  task automatic t_ignore();
    wr(15'h0200, 8'h33, 0, 0, "R4 unprefixed");
    chk_prot(1'b1, "R4 still on");
  endtask

  task automatic t_prefixed();
    arm_prefix("R5 prefix");
    wr(15'h0210, 8'h44, 1, 0, "R5 prefixed write");
    chk_prot(1'b1, "R5 still on");
  endtask

  task automatic t_break_prot();
    wr(15'h5555, 8'hAA, 0, 1, "R8 start");
    wr(15'h0300, 8'h11, 0, 0, "R8 break protected");
    wr(15'h2AAA, 8'h55, 0, 0, "R8 matcher idle");
  endtask

  task automatic t_disable();
    wr(15'h5555, 8'hAA, 0, 1, "R6 d1");
    wr(15'h6AAA, 8'h55, 0, 1, "R7 alias 6AAA");
    wr(15'h5555, 8'h80, 0, 1, "R6 d3");
    wr(15'h1555, 8'hAA, 0, 1, "R7 alias 1555");
    wr(15'h2AAA, 8'h55, 0, 1, "R6 d5");
    chk_prot(1'b1, "R6 before last");
    wr(15'h5555, 8'h20, 0, 1, "R6 d6");
    chk_prot(1'b0, "R6 disarmed");
    wr(15'h0400, 8'h66, 1, 0, "R6 plain after");
  endtask

  task automatic t_break_unprot();
    wr(15'h5555, 8'hAA, 0, 1, "R8 u start");
    wr(15'h0410, 8'h77, 1, 0, "R8 break unprotected");
    wr(15'h5555, 8'hAA, 0, 1, "R8 u s1");
    wr(15'h5555, 8'hAA, 0, 1, "R8 restart on AA");
    wr(15'h2AAA, 8'h55, 0, 1, "R8 after restart");
    wr(15'h0420, 8'h88, 1, 0, "R8 break at step2");
    chk_prot(1'b0, "R8 unchanged");
  endtask

  task automatic t_rst();
    wr(15'h5555, 8'hAA, 0, 1, "R9 s1");
    wr(15'h2AAA, 8'h55, 0, 1, "R9 s2");
    @(negedge clk); rst_n = 1'b0;
    wr(15'h5555, 8'hA0, 0, 0, "R9 during reset");
    @(negedge clk); rst_n = 1'b1;
    wr(15'h5555, 8'hA0, 1, 0, "R9 matcher cleared");
    chk_prot(1'b0, "R9 off kept");
    arm_prefix("R9 arm");
    wr(15'h0500, 8'h99, 1, 0, "R9 arm data");
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk_prot(1'b1, "R9 on kept");
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_plain();
    t_enable();
    t_ignore();
    t_prefixed();
    t_break_prot();
    t_disable();
    t_break_unprot();
    t_rst();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule